// File: doc/BRIEF.md
# Lock Ownership Directory Server

This block is the home directory for a set of mutex identifiers in a multiprocessor system where cores hand lock ownership among themselves by messages. For every lock it holds an entry that names the process which most recently asked for that lock. That entry is the tail of a first-come-first-served waiting queue whose links live with the processes themselves. An acquire request either grants a lock that has no entry, or answers with the process the requester must contact next. In both cases the requester becomes the new tail.

A give-up removes the entry, but only when the caller is still the recorded tail. A stale give-up that crosses a newer request therefore leaves the queue intact. The storage is a small fully associative table. When it has no free slot, a request for a new lock gets a retry answer.

Commands arrive one at a time through a valid/ready port. The lookup and the table update for a command happen together in one cycle. A new command is not taken until the response to the previous one has been presented.

Top module: `lockdir_server`

## Requirements
- R1: After a synchronous reset, `cmd_ready` is 1, `rsp_valid` is 0 and the table holds no entries, so the next acquire of any lock is granted.
- R2: An acquire (`cmd_op`=0) of a lock with no entry, while a slot is free, answers status 0 (granted) with `rsp_owner` equal to the requester and records the requester for that lock.
- R3: An acquire of a lock that has an entry answers status 1 (ask owner) with `rsp_owner` equal to the previously recorded process, and replaces the record with the requester. This also holds when the requester is the recorded process. At most one entry ever matches a lock identifier.
- R4: A give-up (`cmd_op`=1) by the recorded process answers status 3 (done) and removes the entry, so a later acquire of that lock is granted.
- R5: A give-up by any other process, or for a lock with no entry, answers status 3 and changes nothing. A later acquire still sees the old record, or no record.
- R6: An acquire of a lock with no entry while every slot is occupied answers status 2 (busy) with `rsp_owner` 0 and leaves the table unchanged. Acquires of locks already present are still served when the table is full.
- R7: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 from that edge until `rsp_valid` has been high for exactly one cycle, the cycle that starts two edges after acceptance.
- R8: A slot freed by a give-up can be reused by an acquire of a different lock.
- R9: Lock identifiers are compared over their full 16 bits. Identifiers that differ in any bit, including the top bit, are distinct locks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Server can take a command |
| cmd_op | input | 1 | 0 acquire, 1 give-up |
| cmd_lock | input | 16 | Lock identifier |
| cmd_pid | input | 5 | Issuing process identifier |
| rsp_valid | output | 1 | Response present (one-cycle pulse) |
| rsp_status | output | 2 | 0 granted, 1 ask owner, 2 busy, 3 done |
| rsp_owner | output | 5 | Process named by the response |

## Verification
A command taken at clock edge E0 is executed against the table during the following cycle. Its response is registered at edge E1 and is visible between E1 and E2, and `cmd_ready` returns after E2. The bench drives every input on the falling edge. Inside each command task it samples four falling edges: ready before acceptance, ready low with no response one falling edge after acceptance, the response itself one falling edge later, and the pulse gone after that. No effect of a command is ever sampled earlier than the cycle in which it is due. Give-ups that must have no effect are checked through the answer to a later acquire of the same lock.

// File: rtl/lockdir_pkg.sv
package lockdir_pkg;

    localparam int LOCKID_W    = 16;
    localparam int PROC_W      = 5;
    localparam int DIR_ENTRIES = 8;

    typedef enum logic {
        OP_ACQUIRE = 1'b0,
        OP_GIVEUP  = 1'b1
    } op_e;

    typedef enum logic [1:0] {
        ST_GRANT = 2'd0,
        ST_ASK   = 2'd1,
        ST_BUSY  = 2'd2,
        ST_DONE  = 2'd3
    } status_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_EXEC = 2'd1,
        SQ_RESP = 2'd2
    } seq_e;

    typedef struct packed {
        op_e                 op;
        logic [LOCKID_W-1:0] lock;
        logic [PROC_W-1:0]   pid;
    } cmd_t;

    typedef struct packed {
        status_e           status;
        logic [PROC_W-1:0] owner;
    } rsp_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lockdir_pick.sv
module lockdir_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/lockdir_cam.sv
module lockdir_cam
    import lockdir_pkg::*;
#(
    parameter int ENTRIES = DIR_ENTRIES,
    localparam int IDX_W  = idx_width(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [LOCKID_W-1:0] key,
    output logic [ENTRIES-1:0]  match_vec,
    output logic                hit,
    output logic [IDX_W-1:0]    hit_idx,
    output logic [PROC_W-1:0]   hit_owner,
    output logic                free_ok,
    output logic [IDX_W-1:0]    free_idx,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [LOCKID_W-1:0] wr_lock,
    input  logic [PROC_W-1:0]   wr_owner,
    input  logic                clr_en,
    input  logic [IDX_W-1:0]    clr_idx
);
    logic [ENTRIES-1:0]             empty_vec;
    logic [ENTRIES-1:0][PROC_W-1:0] owner_arr;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic                vld_r;
        logic [LOCKID_W-1:0] lock_r;
        logic [PROC_W-1:0]   own_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_r  <= 1'b0;
                lock_r <= '0;
                own_r  <= '0;
            end else if (clr_en && clr_idx == IDX_W'(g)) begin
                vld_r <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                vld_r  <= 1'b1;
                lock_r <= wr_lock;
                own_r  <= wr_owner;
            end
        end

        assign match_vec[g] = vld_r && (lock_r == key);
        assign empty_vec[g] = !vld_r;
        assign owner_arr[g] = own_r;
    end

    lockdir_pick #(.N(ENTRIES), .IDX_W(IDX_W)) hit_pick_i (
        .req(match_vec), .found(hit), .idx(hit_idx)
    );

    lockdir_pick #(.N(ENTRIES), .IDX_W(IDX_W)) free_pick_i (
        .req(empty_vec), .found(free_ok), .idx(free_idx)
    );

    assign hit_owner = owner_arr[hit_idx];
endmodule

// File: rtl/lockdir_ctrl.sv
module lockdir_ctrl
    import lockdir_pkg::*;
#(
    parameter int ENTRIES = DIR_ENTRIES,
    localparam int IDX_W  = idx_width(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  cmd_t                cmd_in,
    output logic                rsp_valid,
    output rsp_t                rsp_out,
    output logic [LOCKID_W-1:0] key,
    input  logic                hit,
    input  logic [IDX_W-1:0]    hit_idx,
    input  logic [PROC_W-1:0]   hit_owner,
    input  logic                free_ok,
    input  logic [IDX_W-1:0]    free_idx,
    output logic                wr_en,
    output logic [IDX_W-1:0]    wr_idx,
    output logic [LOCKID_W-1:0] wr_lock,
    output logic [PROC_W-1:0]   wr_owner,
    output logic                clr_en,
    output logic [IDX_W-1:0]    clr_idx
);
    seq_e seq_q;
    cmd_t cmd_q;
    rsp_t rsp_q;
    rsp_t rsp_d;

    assign cmd_ready = (seq_q == SQ_IDLE);
    assign rsp_valid = (seq_q == SQ_RESP);
    assign rsp_out   = rsp_q;
    assign key       = cmd_q.lock;
    assign wr_lock   = cmd_q.lock;
    assign wr_owner  = cmd_q.pid;

    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = '0;
        clr_en  = 1'b0;
        clr_idx = '0;
        rsp_d   = '{status: ST_DONE, owner: cmd_q.pid};
        if (seq_q == SQ_EXEC) begin
            if (cmd_q.op == OP_ACQUIRE) begin
                if (hit) begin
                    wr_en  = 1'b1;
                    wr_idx = hit_idx;
                    rsp_d  = '{status: ST_ASK, owner: hit_owner};
                end else if (free_ok) begin
                    wr_en  = 1'b1;
                    wr_idx = free_idx;
                    rsp_d  = '{status: ST_GRANT, owner: cmd_q.pid};
                end else begin
                    rsp_d  = '{status: ST_BUSY, owner: '0};
                end
            end else if (hit && hit_owner == cmd_q.pid) begin
                clr_en  = 1'b1;
                clr_idx = hit_idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= SQ_IDLE;
            cmd_q <= '0;
            rsp_q <= '0;
        end else begin
            unique case (seq_q)
                SQ_IDLE: if (cmd_valid) begin
                    cmd_q <= cmd_in;
                    seq_q <= SQ_EXEC;
                end
                SQ_EXEC: begin
                    rsp_q <= rsp_d;
                    seq_q <= SQ_RESP;
                end
                default: seq_q <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lockdir_server.sv
module lockdir_server
    import lockdir_pkg::*;
#(
    parameter int ENTRIES = DIR_ENTRIES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic                cmd_op,
    input  logic [LOCKID_W-1:0] cmd_lock,
    input  logic [PROC_W-1:0]   cmd_pid,
    output logic                rsp_valid,
    output logic [1:0]          rsp_status,
    output logic [PROC_W-1:0]   rsp_owner
);
    localparam int IDX_W = idx_width(ENTRIES);

    cmd_t                cmd_in;
    rsp_t                rsp_out;
    logic [LOCKID_W-1:0] key;
    logic [ENTRIES-1:0]  cam_match;
    logic                cam_hit;
    logic [IDX_W-1:0]    cam_hit_idx;
    logic [PROC_W-1:0]   cam_hit_owner;
    logic                cam_free_ok;
    logic [IDX_W-1:0]    cam_free_idx;
    logic                wr_en;
    logic [IDX_W-1:0]    wr_idx;
    logic [LOCKID_W-1:0] wr_lock;
    logic [PROC_W-1:0]   wr_owner;
    logic                clr_en;
    logic [IDX_W-1:0]    clr_idx;

    assign cmd_in     = '{op: op_e'(cmd_op), lock: cmd_lock, pid: cmd_pid};
    assign rsp_status = rsp_out.status;
    assign rsp_owner  = rsp_out.owner;

    lockdir_ctrl #(.ENTRIES(ENTRIES)) ctrl_i (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_in(cmd_in),
        .rsp_valid(rsp_valid), .rsp_out(rsp_out), .key(key),
        .hit(cam_hit), .hit_idx(cam_hit_idx), .hit_owner(cam_hit_owner),
        .free_ok(cam_free_ok), .free_idx(cam_free_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_lock(wr_lock), .wr_owner(wr_owner),
        .clr_en(clr_en), .clr_idx(clr_idx)
    );

    lockdir_cam #(.ENTRIES(ENTRIES)) cam_i (
        .clk(clk), .rst(rst), .key(key), .match_vec(cam_match),
        .hit(cam_hit), .hit_idx(cam_hit_idx), .hit_owner(cam_hit_owner),
        .free_ok(cam_free_ok), .free_idx(cam_free_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_lock(wr_lock), .wr_owner(wr_owner),
        .clr_en(clr_en), .clr_idx(clr_idx)
    );
endmodule

// File: rtl/lockdir_server_chk.sv
module lockdir_server_chk
    import lockdir_pkg::*;
#(
    parameter int ENTRIES = DIR_ENTRIES
) (
    input logic               clk,
    input logic               rst,
    input logic               cmd_valid,
    input logic               cmd_ready,
    input logic [PROC_W-1:0]  cmd_pid,
    input logic               rsp_valid,
    input logic [1:0]         rsp_status,
    input logic [PROC_W-1:0]  rsp_owner,
    input logic [ENTRIES-1:0] match_vec,
    input logic               free_ok
);
    p_single_entry_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec));

    p_resp_latency_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |-> ##2 rsp_valid);

    p_hold_off_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    p_no_accept_in_resp_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !cmd_ready);

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    p_grant_owner_r2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == ST_GRANT) |-> rsp_owner == $past(cmd_pid, 2));

    p_busy_only_full_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == ST_BUSY) |-> !$past(free_ok));

    p_busy_owner_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == ST_BUSY) |-> rsp_owner == '0);
endmodule

bind lockdir_server lockdir_server_chk #(.ENTRIES(ENTRIES)) chk_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_pid(cmd_pid), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_owner(rsp_owner), .match_vec(cam_match), .free_ok(cam_free_ok)
);

// File: tb/lockdir_server_tb_top.sv
`timescale 1ns/1ps
module lockdir_server_tb_top;
    localparam logic       ACQ = 1'b0;
    localparam logic       REL = 1'b1;
    localparam logic [1:0] GRANT = 2'd0;
    localparam logic [1:0] ASK   = 2'd1;
    localparam logic [1:0] BUSY  = 2'd2;
    localparam logic [1:0] DONE  = 2'd3;
    localparam logic [15:0] LK_A = 16'h1234;
    localparam logic [15:0] LK_B = 16'h0042;
    localparam logic [15:0] LK_C = 16'h9234;
    localparam logic [15:0] LK_N = 16'h0ABC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_op = 1'b0;
    logic [15:0] cmd_lock = '0;
    logic [4:0]  cmd_pid = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [4:0]  rsp_owner;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    lockdir_server dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_lock(cmd_lock), .cmd_pid(cmd_pid),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_owner(rsp_owner)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready after reset", int'(cmd_ready), 1);
        check("R1 no response after reset", int'(rsp_valid), 0);
    endtask

    task automatic issue(input logic op, input logic [15:0] lk, input logic [4:0] pid,
                         input logic [1:0] exp_st, input logic [4:0] exp_own,
                         input string tag);
        @(negedge clk);
        check({"R7 ready before ", tag}, int'(cmd_ready), 1);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_lock  = lk;
        cmd_pid   = pid;
        @(negedge clk);
        cmd_valid = 1'b0;
        check({"R7 ready low ", tag}, int'(cmd_ready), 0);
        check({"R7 no early response ", tag}, int'(rsp_valid), 0);
        @(negedge clk);
        check({"R7 response due ", tag}, int'(rsp_valid), 1);
        check({tag, " status"}, int'(rsp_status), int'(exp_st));
        check({tag, " owner"}, int'(rsp_owner), int'(exp_own));
        @(negedge clk);
        check({"R7 pulse ends ", tag}, int'(rsp_valid), 0);
    endtask

    task automatic t_grant();
        issue(ACQ, LK_A, 5'd3, GRANT, 5'd3, "R1 R2 first acquire granted");
    endtask

    task automatic t_queue();
        issue(ACQ, LK_A, 5'd5, ASK, 5'd3, "R3 second requester asks first");
        issue(ACQ, LK_A, 5'd7, ASK, 5'd5, "R3 tail advances");
        issue(ACQ, LK_A, 5'd7, ASK, 5'd7, "R3 self re-request");
    endtask

    task automatic t_stale_giveup();
        issue(REL, LK_A, 5'd3, DONE, 5'd3, "R5 non-owner give-up");
        issue(ACQ, LK_A, 5'd9, ASK, 5'd7, "R5 record kept after stale give-up");
        issue(REL, LK_B, 5'd1, DONE, 5'd1, "R5 give-up of absent lock");
        issue(ACQ, LK_B, 5'd1, GRANT, 5'd1, "R5 absent give-up created nothing");
    endtask

    task automatic t_owner_giveup();
        issue(REL, LK_A, 5'd9, DONE, 5'd9, "R4 owner give-up");
        issue(ACQ, LK_A, 5'd4, GRANT, 5'd4, "R4 lock free after give-up");
    endtask

    task automatic t_key_width();
        issue(ACQ, LK_C, 5'd2, GRANT, 5'd2, "R9 top bit distinguishes locks");
        issue(ACQ, LK_A, 5'd6, ASK, 5'd4, "R9 original lock untouched");
    endtask

    task automatic t_full();
        for (int i = 0; i < 5; i++)
            issue(ACQ, 16'h0100 + 16'(i), 5'(10 + i), GRANT, 5'(10 + i), "R2 fill slot");
        issue(ACQ, LK_N, 5'd20, BUSY, 5'd0, "R6 new lock refused when full");
        issue(ACQ, LK_B, 5'd21, ASK, 5'd1, "R6 present lock served when full");
        issue(ACQ, LK_N, 5'd20, BUSY, 5'd0, "R6 refusal left table unchanged");
        issue(REL, LK_C, 5'd2, DONE, 5'd2, "R8 free one slot");
        issue(ACQ, LK_N, 5'd20, GRANT, 5'd20, "R8 freed slot reused");
        issue(ACQ, 16'h0777, 5'd22, BUSY, 5'd0, "R6 full again");
    endtask

    task automatic t_reset_clears();
        do_reset();
        issue(ACQ, LK_B, 5'd8, GRANT, 5'd8, "R1 reset cleared table");
    endtask

    initial begin
        do_reset();
        t_grant();
        t_queue();
        t_stale_giveup();
        t_owner_giveup();
        t_key_width();
        t_full();
        t_reset_clears();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule